// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the timing core of an integrating analog-to-digital converter. It cycles a converter through three phases: a zeroing phase, a fixed-length phase that integrates the input signal, and a phase that ramps the integrator back towards zero against a reference. It counts clock cycles in each phase. The analog section sits outside the block. The block only sees the comparator as a one-bit input, `cmp_i`, and drives one select line per phase.

The de-integrate phase ends on the first cycle in which the comparator level differs from the polarity captured at the end of integration. The count in that cycle is the conversion result. If no crossing comes, a count ceiling ends the phase and flags over-range. The result is copied into an output latch a fixed number of cycles later. A status line is high from the start of integration until that copy is made, so readers know when not to sample.

A hold request (`run_i` low) is looked at only in the last zeroing cycle. While held, the sequencer parks in the zeroing phase with its count frozen. The length of the zeroing phase depends on the previous result, so the overall conversion rhythm adapts to where the last conversion finished.

Top module: `dsq_sequencer`

## Requirements
- R1: A synchronous active-high `rst` leaves the block in the zeroing phase (`phase_az_o`=1) with `count_o`=0, `result_o`=0, `polarity_o`=0, `overrange_o`=0, `status_o`=0 and `latch_o`=0.
- R2: In each phase, `count_o` starts at 0 and rises by one per cycle. The zeroing phase lasts AZ_MIN + min(P mod 2^EW, AZ_MAX-AZ_MIN) cycles. Here P is the most recent conversion result (0 after reset) and EW = ceil(log2(AZ_MAX-AZ_MIN+1)), with a minimum of 1.
- R3: `run_i` is sampled only in the final zeroing cycle. Toggling it earlier in the zeroing phase has no effect on the phase length or the next phase.
- R4: If `run_i` is 0 in the final zeroing cycle, the block holds. `phase_az_o` stays 1, `count_o` stays frozen, `status_o` stays 0, and no integration starts. Integration begins on the cycle after `run_i`=1 is sampled.
- R5: The integrate phase lasts exactly INT_CNT cycles. `polarity_o` later reports the `cmp_i` level sampled in its final cycle.
- R6: The de-integrate phase ends on the first cycle in which `cmp_i` differs from the captured polarity. The result is the `count_o` value of that cycle, with over-range 0.
- R7: If no crossing happens by count DEINT_MAX-1, the phase ends there. The result is DEINT_MAX-1 with over-range 1.
- R8: `result_o`, `polarity_o` and `overrange_o` change only together with a one-cycle `latch_o` pulse. That pulse is visible in the zeroing cycle where `count_o`=LATCH_DLY, i.e. LATCH_DLY cycles after the cycle that ended de-integration.
- R9: `status_o` rises in the first integrate cycle and stays 1 through de-integration. It falls in the same cycle as the `latch_o` pulse.
- R10: Exactly one of `phase_az_o`, `phase_int_o`, `phase_deint_o` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 = free-running, 0 = hold request |
| cmp_i | input | 1 | Zero-crossing comparator level |
| phase_az_o | output | 1 | Zeroing phase select (also high while held) |
| phase_int_o | output | 1 | Signal integrate phase select |
| phase_deint_o | output | 1 | De-integrate phase select |
| count_o | output | CNT_W | Cycle count within the current phase |
| result_o | output | CNT_W | Latched conversion count |
| polarity_o | output | 1 | Latched polarity |
| overrange_o | output | 1 | Latched over-range flag |
| latch_o | output | 1 | One-cycle output latch update strobe |
| status_o | output | 1 | Conversion in progress / latch not yet updated |

## Verification
All outputs are registered, so a phase change is visible in the cycle after its final count. The bench reads every output at the falling edge and walks `count_o` through each phase one falling edge at a time. When it flips `cmp_i` during the cycle where `count_o` equals the target, that count becomes the result. The strobe and the new output latch values are due LATCH_DLY cycles after the ending edge. The bench's monitor therefore requires them in the zeroing cycle with `count_o`=LATCH_DLY, and it checks that `status_o` drops in that same sample. The hold release is due one cycle after `run_i` rises, and the bench checks for integrate count 0 at the very next falling edge.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_HOLD  = 2'd1,
        PH_INT   = 2'd2,
        PH_DEINT = 2'd3
    } dsq_phase_e;

    function automatic int dsq_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int dsq_ext_w(input int span);
        return (span > 1) ? $clog2(span) : 1;
    endfunction

endpackage

// File: rtl/dsq_az_len.sv
module dsq_az_len #(
    parameter int AZ_MIN = 1790,
    parameter int AZ_MAX = 2041,
    parameter int CNT_W  = 13
) (
    input  logic [dsq_pkg::dsq_ext_w(AZ_MAX-AZ_MIN+1)-1:0] last_low_i,
    output logic [CNT_W-1:0]                               az_last_o
);
    localparam int SPAN = AZ_MAX - AZ_MIN + 1;
    localparam int EW   = dsq_pkg::dsq_ext_w(SPAN);

    logic [EW-1:0] ext;

    always_comb begin
        if (int'(last_low_i) > SPAN - 1) ext = EW'(SPAN - 1);
        else                             ext = last_low_i;
        az_last_o = CNT_W'(AZ_MIN - 1) + CNT_W'(ext);
    end
endmodule

// File: rtl/dsq_latch_timer.sv
module dsq_latch_timer #(
    parameter int LATCH_DLY = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic fire_o
);
    localparam int DW = $clog2(LATCH_DLY + 1);
    localparam logic [DW-1:0] DLY_LAST = DW'(LATCH_DLY - 1);

    typedef struct packed {
        logic          pend;
        logic [DW-1:0] dly;
    } tmr_t;

    tmr_t q, d;

    assign fire_o = q.pend && (q.dly == DLY_LAST);

    always_comb begin
        d = q;
        if (start_i) begin
            d.pend = 1'b1;
            d.dly  = '0;
        end else if (q.pend) begin
            if (q.dly == DLY_LAST) d.pend = 1'b0;
            else                   d.dly  = q.dly + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    a_r8_fire_single: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !fire_o);
endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer #(
    parameter int AZ_MIN    = 1790,
    parameter int AZ_MAX    = 2041,
    parameter int INT_CNT   = 2048,
    parameter int DEINT_MAX = 4096,
    parameter int LATCH_DLY = 7,
    parameter int CNT_W     = $clog2(dsq_pkg::dsq_max3(AZ_MAX, INT_CNT, DEINT_MAX) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             cmp_i,
    output logic             phase_az_o,
    output logic             phase_int_o,
    output logic             phase_deint_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] result_o,
    output logic             polarity_o,
    output logic             overrange_o,
    output logic             latch_o,
    output logic             status_o
);
    import dsq_pkg::*;

    localparam int EW = dsq_ext_w(AZ_MAX - AZ_MIN + 1);
    localparam logic [CNT_W-1:0] INT_LAST   = CNT_W'(INT_CNT - 1);
    localparam logic [CNT_W-1:0] DEINT_LAST = CNT_W'(DEINT_MAX - 1);

    typedef struct packed {
        dsq_phase_e       st;
        logic [CNT_W-1:0] cnt;
        logic             pol;
        logic [CNT_W-1:0] cap;
        logic             cap_pol;
        logic             cap_ovr;
        logic [CNT_W-1:0] res;
        logic             res_pol;
        logic             res_ovr;
        logic             latch;
        logic             status;
    } seq_t;

    seq_t             q, d;
    logic [CNT_W-1:0] az_last;
    logic             deint_end;
    logic             fire;

    dsq_az_len #(.AZ_MIN(AZ_MIN), .AZ_MAX(AZ_MAX), .CNT_W(CNT_W)) u_az_len (
        .last_low_i (q.cap[EW-1:0]),
        .az_last_o  (az_last)
    );

    dsq_latch_timer #(.LATCH_DLY(LATCH_DLY)) u_latch_tmr (
        .clk     (clk),
        .rst     (rst),
        .start_i (deint_end),
        .fire_o  (fire)
    );

    always_comb begin
        d         = q;
        d.latch   = 1'b0;
        deint_end = 1'b0;
        unique case (q.st)
            PH_AZ: begin
                if (q.cnt == az_last) begin
                    if (run_i) begin
                        d.st     = PH_INT;
                        d.cnt    = '0;
                        d.status = 1'b1;
                    end else begin
                        d.st = PH_HOLD;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                if (run_i) begin
                    d.st     = PH_INT;
                    d.cnt    = '0;
                    d.status = 1'b1;
                end
            end
            PH_INT: begin
                if (q.cnt == INT_LAST) begin
                    d.st  = PH_DEINT;
                    d.cnt = '0;
                    d.pol = cmp_i;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_DEINT: begin
                if ((cmp_i != q.pol) || (q.cnt == DEINT_LAST)) begin
                    deint_end = 1'b1;
                    d.cap     = q.cnt;
                    d.cap_pol = q.pol;
                    d.cap_ovr = (cmp_i == q.pol);
                    d.st      = PH_AZ;
                    d.cnt     = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = PH_AZ;
        endcase
        if (fire) begin
            d.res     = q.cap;
            d.res_pol = q.cap_pol;
            d.res_ovr = q.cap_ovr;
            d.latch   = 1'b1;
            d.status  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= PH_AZ;
        end else begin
            q <= d;
        end
    end

    assign phase_az_o    = (q.st == PH_AZ) || (q.st == PH_HOLD);
    assign phase_int_o   = (q.st == PH_INT);
    assign phase_deint_o = (q.st == PH_DEINT);
    assign count_o       = q.cnt;
    assign result_o      = q.res;
    assign polarity_o    = q.res_pol;
    assign overrange_o   = q.res_ovr;
    assign latch_o       = q.latch;
    assign status_o      = q.status;

    a_r3_no_early_exit: assert property (@(posedge clk) disable iff (rst)
        (phase_az_o && !$isunknown(az_last) && q.st == PH_AZ && count_o != az_last)
        |=> (q.st == PH_AZ));
    a_r4_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (q.st == PH_HOLD && !run_i) |=> (q.st == PH_HOLD && $stable(count_o) && !status_o));
    a_r5_int_len: assert property (@(posedge clk) disable iff (rst)
        (phase_int_o && count_o == INT_LAST) |=> (phase_deint_o && count_o == '0));
    a_r6_cross_ends: assert property (@(posedge clk) disable iff (rst)
        (phase_deint_o && cmp_i != q.pol) |=> (phase_az_o && !q.cap_ovr));
    a_r7_deint_bound: assert property (@(posedge clk) disable iff (rst)
        phase_deint_o |-> (count_o <= DEINT_LAST));
    a_r8_result_steady: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(result_o));
    a_r9_status_busy: assert property (@(posedge clk) disable iff (rst)
        (phase_int_o || phase_deint_o) |-> status_o);
    a_r10_phase_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones({phase_az_o, phase_int_o, phase_deint_o}) == 1);
endmodule

// File: tb/dsq_sequencer_tb.sv
module dsq_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AZ_MIN     = 20;
    localparam int AZ_MAX     = 25;
    localparam int INT_CNT    = 16;
    localparam int DEINT_MAX  = 32;
    localparam int LATCH_DLY  = 7;
    localparam int CNT_W      = 6;
    localparam int EXT_MOD    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_i = 1'b1;
    logic cmp_i = 1'b0;
    logic phase_az_o, phase_int_o, phase_deint_o;
    logic [CNT_W-1:0] count_o, result_o;
    logic polarity_o, overrange_o, latch_o, status_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsq_sequencer #(.AZ_MIN(AZ_MIN), .AZ_MAX(AZ_MAX), .INT_CNT(INT_CNT),
                    .DEINT_MAX(DEINT_MAX), .LATCH_DLY(LATCH_DLY), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .run_i(run_i), .cmp_i(cmp_i),
        .phase_az_o(phase_az_o), .phase_int_o(phase_int_o), .phase_deint_o(phase_deint_o),
        .count_o(count_o), .result_o(result_o), .polarity_o(polarity_o),
        .overrange_o(overrange_o), .latch_o(latch_o), .status_o(status_o)
    );

    typedef struct { int cnt; bit pol; bit ovr; } exp_t;
    exp_t exp_q[$];

    int  n_chk = 0;
    int  n_bad = 0;
    int  last_res = 0;
    bit  done = 1'b0;
    bit  mon_on = 1'b0;
    int  steady_bad = 0;
    int  status_bad = 0;
    int  phase_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic run_conv(input bit pol, input int k, input bit hold, input bit glitch);
        int ext, exp_len, bad, got, exp_res;
        bit exp_ovr;
        ext = last_res % EXT_MOD;
        if (ext > AZ_MAX - AZ_MIN) ext = AZ_MAX - AZ_MIN;
        exp_len = AZ_MIN + ext;
        cmp_i = pol;
        bad = 0; got = 0;
        // R2 / R3: zeroing phase walks count 0..len-1; early run_i changes ignored
        while (phase_az_o && !(got > 0 && count_o == CNT_W'(got - 1))) begin
            if (int'(count_o) != got) bad++;
            if (glitch && got == 2) run_i = 1'b0;
            if (glitch && got == 4) run_i = 1'b1;
            if (hold && got == exp_len - 3) run_i = 1'b0;
            got++;
            @(negedge clk);
        end
        check(bad == 0, "R2 zeroing count sequence", bad, 0);
        check(got == exp_len, hold ? "R2 zeroing length (hold case)" :
              (glitch ? "R3 zeroing length with ignored toggles" : "R2 zeroing length"),
              got, exp_len);
        if (hold) begin
            bad = 0;
            for (int h = 0; h < 5; h++) begin
                if (!phase_az_o || phase_int_o || int'(count_o) != exp_len - 1 || status_o) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R4 hold keeps zeroing, count frozen", bad, 0);
            run_i = 1'b1;
            @(negedge clk);
        end
        check(phase_int_o && count_o == 0, "R4/R5 integrate entry", int'(count_o), 0);
        check(status_o == 1'b1, "R9 status rises at integrate", int'(status_o), 1);
        bad = 0; got = 0;
        while (phase_int_o) begin
            if (int'(count_o) != got) bad++;
            got++;
            @(negedge clk);
        end
        check(bad == 0 && got == INT_CNT, "R5 integrate length", got, INT_CNT);
        exp_ovr = (k > DEINT_MAX - 1);
        exp_res = exp_ovr ? DEINT_MAX - 1 : k;
        bad = 0; got = 0;
        while (phase_deint_o) begin
            if (int'(count_o) != got) bad++;
            if (got == k) cmp_i = !pol;
            got++;
            @(negedge clk);
        end
        check(bad == 0 && got == exp_res + 1, exp_ovr ? "R7 timeout length" : "R6 crossing length",
              got, exp_res + 1);
        exp_q.push_back('{cnt: exp_res, pol: pol, ovr: exp_ovr});
        last_res = exp_res;
    endtask

    // Monitor / scoreboard
    initial begin
        logic [CNT_W-1:0] prev_res;
        bit prev_status;
        exp_t e;
        prev_res = '0;
        prev_status = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if ($countones({phase_az_o, phase_int_o, phase_deint_o}) != 1) phase_bad++;
                if ((phase_int_o || phase_deint_o) && !status_o) status_bad++;
                if (latch_o) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8 unexpected latch pulse", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check(int'(result_o) == e.cnt, e.ovr ? "R7 latched result" : "R6 latched result",
                              int'(result_o), e.cnt);
                        check(overrange_o == e.ovr, e.ovr ? "R7 overrange flag" : "R6 overrange flag",
                              int'(overrange_o), int'(e.ovr));
                        check(polarity_o == e.pol, "R5 latched polarity", int'(polarity_o), int'(e.pol));
                    end
                    check(phase_az_o && int'(count_o) == LATCH_DLY, "R8 latch timing",
                          int'(count_o), LATCH_DLY);
                    check(!status_o && prev_status, "R9 status falls with latch",
                          int'(status_o), 0);
                end else if (result_o != prev_res) begin
                    steady_bad++;
                end
                prev_res = result_o;
                prev_status = status_o;
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(phase_az_o && !phase_int_o && !phase_deint_o, "R1 reset phase", int'(phase_az_o), 1);
        check(count_o == 0 && result_o == 0, "R1 reset counters", int'(count_o) + int'(result_o), 0);
        check(!status_o && !latch_o && !polarity_o && !overrange_o, "R1 reset flags",
              int'(status_o) + int'(latch_o) + int'(polarity_o) + int'(overrange_o), 0);
        rst = 1'b0;
        mon_on = 1'b1;
        run_conv(1'b1, 5,  1'b0, 1'b0);
        run_conv(1'b0, 13, 1'b0, 1'b1);
        run_conv(1'b1, 40, 1'b1, 1'b0);
        run_conv(1'b0, 0,  1'b0, 1'b0);
        run_conv(1'b1, 10, 1'b0, 1'b0);
        run_conv(1'b0, 31, 1'b0, 1'b0);
        run_conv(1'b1, 3,  1'b0, 1'b0);
        repeat (LATCH_DLY + 3) @(negedge clk);
        check(exp_q.size() == 0, "R8 every result latched", exp_q.size(), 0);
        check(steady_bad == 0, "R8 outputs steady without latch", steady_bad, 0);
        check(status_bad == 0, "R9 status high while busy", status_bad, 0);
        check(phase_bad == 0, "R10 one phase select at a time", phase_bad, 0);
        done = 1'b1;
        finish_run();
    end
endmodule